// File: doc/BRIEF.md
# Target-Cycle Channel Wrapper

This block lets a modelled hardware unit step through simulated ("target") clock cycles while the surrounding logic runs on a faster host clock. Each input channel ends in a small queue of tokens. Each output channel starts with one. A token is a presence flag plus a data field. A token with the flag clear stands for a target cycle in which nothing was sent, and it still counts as one cycle of traffic. The wrapper raises a one-host-cycle advance strobe only when four things hold at once: every input queue holds a token, every output queue has a free slot, the unit is not busy, and the debug controls permit a step. On that strobe the unit consumes one token from each input and hands one token to each output.

Each input channel can be given a target latency L. Its queue then comes out of reset already holding L idle tokens, so the receiving unit can run L target cycles before the sender's first real token arrives. A 32-bit counter records how many target cycles have elapsed.

Debug controls can freeze the unit and release it one target cycle at a time. A free-running mode drops the cycle accounting so that data flows as fast as the host allows.

Top module: `tcw_wrapper`

## Requirements
- R1: After reset, input channel i holds exactly LAT(i) idle tokens. An idle token has flag 0 and data 0. LAT(i) is the LAT_W-bit field i of parameter IN_LAT, with channel 0 in the least significant field. These tokens are delivered to the unit ahead of any token pushed on that channel.
- R2: `tgt_adv` is never high while any input queue is empty.
- R3: `tgt_adv` is never high while any output queue is full. Tokens pushed while the outputs are full wait in the input queues, and no advance happens.
- R4: `tgt_adv` is never high while `unit_busy` is high.
- R5: On each advance, one token is removed from the head of every input queue and the unit's token is appended to every output queue. Every channel keeps its order, and no token is lost or duplicated.
- R6: `in_ready[i]` is low exactly when input queue i is full, and a push on a full queue is discarded. An `out_pop` on an empty output queue has no effect.
- R7: `tgt_cycle` is zero after reset. It rises by one on every advance made outside free-running mode.
- R8: While `dbg_stall` is high, no advance happens unless a `dbg_step` pulse was seen. Each pulse permits exactly one advance, which comes in the cycle after the pulse or later.
- R9: With `fast_mode` high and `dbg_stall` low, idle tokens at an input head are discarded without an advance. Idle tokens from the unit are not queued, and `tgt_cycle` holds its value.
- R10: After reset all output queues are empty, and every input queue with latency below its depth reports ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| in_push | input | NUM_IN | Sender offers a token on each input channel |
| in_flag | input | NUM_IN | Presence flag of the offered token (1 = message, 0 = idle) |
| in_data | input | NUM_IN*8 | Data of the offered token; channel i in bits [i*8 +: 8] |
| in_ready | output | NUM_IN | Input queue has room |
| unit_in_flag | output | NUM_IN | Head-token flag presented to the unit |
| unit_in_data | output | NUM_IN*8 | Head-token data presented to the unit |
| unit_out_flag | input | NUM_OUT | Flag of the token the unit produces this target cycle |
| unit_out_data | input | NUM_OUT*8 | Data of the token the unit produces |
| unit_busy | input | 1 | Unit cannot take another target cycle yet |
| tgt_adv | output | 1 | One-cycle target advance strobe |
| out_valid | output | NUM_OUT | Output queue holds a token |
| out_flag | output | NUM_OUT | Flag of the output head token |
| out_data | output | NUM_OUT*8 | Data of the output head token |
| out_pop | input | NUM_OUT | Receiver takes the output head token |
| dbg_stall | input | 1 | Freeze target advancement |
| dbg_step | input | 1 | Permit one advance while frozen |
| fast_mode | input | 1 | Free-running mode without cycle accounting |
| tgt_cycle | output | CNT_W | Elapsed target cycles |

## Verification
Assertions check four things on every host cycle. The advance strobe never coincides with an empty input, a full output or a busy unit. Queue occupancy stays within depth, and a full or empty queue stays that way when nothing drains or fills it. A frozen unit never advances twice on one step permission.

Some properties only show up in the bench's scenarios. These cover token conservation and ordering under random gaps on both sides, the idle prefix produced by a nonzero latency, and the exact counter values after stepping and backpressure. They also cover the discarding of idle heads in free-running mode and the harmlessness of pushes on a full queue and pops on an empty one.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

    parameter int unsigned TOK_DW = 8;

    typedef struct packed {
        logic              vld;
        logic [TOK_DW-1:0] data;
    } tok_t;

    typedef enum logic [1:0] {
        ADV_RUN  = 2'd0,
        ADV_HOLD = 2'd1,
        ADV_FREE = 2'd2
    } adv_mode_e;

    // Extract field idx (lw bits wide) of a packed latency vector.
    function automatic int unsigned lat_at(input logic [63:0] vec,
                                           input int unsigned idx,
                                           input int unsigned lw);
        logic [63:0] sh;
        logic [63:0] mask;
        sh   = vec >> (idx * lw);
        mask = (64'd1 << lw) - 64'd1;
        return int'(sh & mask);
    endfunction

endpackage

// File: rtl/tcw_fifo.sv
module tcw_fifo
    import tcw_pkg::*;
#(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned PRELOAD = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  tok_t din,
    output logic full,
    input  logic pop,
    output tok_t dout,
    output logic empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
    localparam logic [AW-1:0] WP_RST = AW'(PRELOAD % DEPTH);
    localparam logic [CW-1:0] CNT_RST = CW'(PRELOAD);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    tok_t          mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr, rd;

    assign full  = (cnt == CNT_MAX);
    assign empty = (cnt == '0);
    assign wr    = push & ~full;
    assign rd    = pop & ~empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
            wp  <= WP_RST;
            rp  <= '0;
            cnt <= CNT_RST;
        end else begin
            if (wr) begin
                mem[wp] <= din;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({wr, rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R6: occupancy never exceeds the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_MAX);

    // R6: a full queue that is not drained stays full (extra push discarded)
    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

    // R6: an empty queue that is not filled stays empty (pop ignored)
    a_r6_empty_holds: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);

endmodule

// File: rtl/tcw_adv_ctl.sv
module tcw_adv_ctl
    import tcw_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             step,
    input  logic             fast,
    input  logic             go_ok,
    output logic             fire,
    output logic             skip_idle,
    output logic [CNT_W-1:0] cycle
);
    adv_mode_e mode;
    logic      pend;
    logic      permit;

    always_comb begin
        if (stall)     mode = ADV_HOLD;
        else if (fast) mode = ADV_FREE;
        else           mode = ADV_RUN;
    end

    assign permit    = (mode != ADV_HOLD) | pend;
    assign fire      = go_ok & permit;
    assign skip_idle = (mode == ADV_FREE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (mode != ADV_HOLD) begin
            pend <= 1'b0;
        end else if (fire) begin
            pend <= 1'b0;
        end else if (step) begin
            pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             cycle <= '0;
        else if (fire && mode != ADV_FREE)   cycle <= cycle + 1'b1;
    end

    // R8: a frozen unit advances only once per step permission
    a_r8_one_per_step: assert property (@(posedge clk) disable iff (rst)
        (stall && fire) |=> (!stall || !fire));

    // R8: frozen with no pending step means no advance
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (stall && !pend) |-> !fire);

    // R9: the counter does not move in free-running mode
    a_r9_free_hold: assert property (@(posedge clk) disable iff (rst)
        (fast && !stall) |=> $stable(cycle));

endmodule

// File: rtl/tcw_wrapper.sv
module tcw_wrapper
    import tcw_pkg::*;
#(
    parameter int unsigned NUM_IN    = 2,
    parameter int unsigned NUM_OUT   = 2,
    parameter int unsigned IN_DEPTH  = 4,
    parameter int unsigned OUT_DEPTH = 4,
    parameter int unsigned LAT_W     = 4,
    parameter logic [NUM_IN*LAT_W-1:0] IN_LAT = 'h2,
    parameter int unsigned CNT_W     = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_IN-1:0]        in_push,
    input  logic [NUM_IN-1:0]        in_flag,
    input  logic [NUM_IN*TOK_DW-1:0] in_data,
    output logic [NUM_IN-1:0]        in_ready,
    output logic [NUM_IN-1:0]        unit_in_flag,
    output logic [NUM_IN*TOK_DW-1:0] unit_in_data,
    input  logic [NUM_OUT-1:0]       unit_out_flag,
    input  logic [NUM_OUT*TOK_DW-1:0] unit_out_data,
    input  logic                     unit_busy,
    output logic                     tgt_adv,
    output logic [NUM_OUT-1:0]       out_valid,
    output logic [NUM_OUT-1:0]       out_flag,
    output logic [NUM_OUT*TOK_DW-1:0] out_data,
    input  logic [NUM_OUT-1:0]       out_pop,
    input  logic                     dbg_stall,
    input  logic                     dbg_step,
    input  logic                     fast_mode,
    output logic [CNT_W-1:0]         tgt_cycle
);
    localparam int unsigned DW = TOK_DW;

    logic [NUM_IN-1:0]  in_empty, in_full, in_ok, in_pop;
    logic [NUM_OUT-1:0] out_empty, out_full, out_push;
    tok_t               in_head  [NUM_IN];
    tok_t               out_head [NUM_OUT];
    logic               go_ok, fire, skip_idle;

    assign go_ok   = (&in_ok) & ~(|out_full) & ~unit_busy;
    assign tgt_adv = fire;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        localparam int unsigned LAT_I = lat_at(64'(IN_LAT), i, LAT_W);
        tok_t in_tok;
        assign in_tok.vld  = in_flag[i];
        assign in_tok.data = in_data[i*DW +: DW];

        tcw_fifo #(.DEPTH(IN_DEPTH), .PRELOAD(LAT_I)) u_q (
            .clk  (clk),
            .rst  (rst),
            .push (in_push[i]),
            .din  (in_tok),
            .full (in_full[i]),
            .pop  (in_pop[i]),
            .dout (in_head[i]),
            .empty(in_empty[i])
        );

        assign in_ok[i]  = ~in_empty[i] & (in_head[i].vld | ~skip_idle);
        assign in_pop[i] = fire | (skip_idle & ~in_empty[i] & ~in_head[i].vld);
        assign in_ready[i]           = ~in_full[i];
        assign unit_in_flag[i]       = in_head[i].vld;
        assign unit_in_data[i*DW +: DW] = in_head[i].data;
    end

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        tok_t o_tok;
        assign o_tok.vld  = unit_out_flag[j];
        assign o_tok.data = unit_out_data[j*DW +: DW];
        assign out_push[j] = fire & (o_tok.vld | ~skip_idle);

        tcw_fifo #(.DEPTH(OUT_DEPTH), .PRELOAD(0)) u_q (
            .clk  (clk),
            .rst  (rst),
            .push (out_push[j]),
            .din  (o_tok),
            .full (out_full[j]),
            .pop  (out_pop[j]),
            .dout (out_head[j]),
            .empty(out_empty[j])
        );

        assign out_valid[j]           = ~out_empty[j];
        assign out_flag[j]            = out_head[j].vld;
        assign out_data[j*DW +: DW]   = out_head[j].data;
    end

    tcw_adv_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .stall    (dbg_stall),
        .step     (dbg_step),
        .fast     (fast_mode),
        .go_ok    (go_ok),
        .fire     (fire),
        .skip_idle(skip_idle),
        .cycle    (tgt_cycle)
    );

    // R2: every input queue holds a token when the unit advances
    a_r2_inputs_present: assert property (@(posedge clk) disable iff (rst)
        tgt_adv |-> (in_empty == '0));

    // R3: every output queue has room when the unit advances
    a_r3_outputs_room: assert property (@(posedge clk) disable iff (rst)
        tgt_adv |-> (out_full == '0));

    // R4: no advance while the unit reports busy
    a_r4_not_busy: assert property (@(posedge clk) disable iff (rst)
        tgt_adv |-> !unit_busy);

    // R7: outside free-running mode each advance bumps the counter
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (tgt_adv && !fast_mode) |=> (tgt_cycle != $past(tgt_cycle)));

endmodule

// File: tb/tcw_wrapper_bench.sv
module tcw_wrapper_bench;

    localparam int NI = 2;
    localparam int NO = 2;
    localparam int NV = 12;

    // stimulus table {flag, data}; channel 1 uses data ^ 8'h5A
    localparam logic [8:0] VEC [NV] = '{
        9'h110, 9'h121, 9'h03C, 9'h142, 9'h15F, 9'h000,
        9'h17E, 9'h180, 9'h19B, 9'h0A4, 9'h1C3, 9'h1FF
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [NI-1:0]   in_push = '0, in_flag = '0, in_ready;
    logic [NI*8-1:0] in_data = '0;
    logic [NI-1:0]   u_in_flag;
    logic [NI*8-1:0] u_in_data;
    logic [NO-1:0]   u_out_flag;
    logic [NO*8-1:0] u_out_data;
    logic            unit_busy = 1'b0;
    logic            tgt_adv;
    logic [NO-1:0]   out_valid, out_flag;
    logic [NO*8-1:0] out_data;
    logic [NO-1:0]   out_pop = '0;
    logic            dbg_stall = 1'b0, dbg_step = 1'b0, fast_mode = 1'b0;
    logic [31:0]     tgt_cycle;

    // unit model: channel 0 adds one, channel 1 passes through
    always_comb begin
        u_out_flag        = u_in_flag;
        u_out_data[7:0]   = u_in_data[7:0] + 8'd1;
        u_out_data[15:8]  = u_in_data[15:8];
    end

    tcw_wrapper u_tcw_wrapper (
        .clk(clk), .rst(rst),
        .in_push(in_push), .in_flag(in_flag), .in_data(in_data), .in_ready(in_ready),
        .unit_in_flag(u_in_flag), .unit_in_data(u_in_data),
        .unit_out_flag(u_out_flag), .unit_out_data(u_out_data),
        .unit_busy(unit_busy), .tgt_adv(tgt_adv),
        .out_valid(out_valid), .out_flag(out_flag), .out_data(out_data), .out_pop(out_pop),
        .dbg_stall(dbg_stall), .dbg_step(dbg_step), .fast_mode(fast_mode),
        .tgt_cycle(tgt_cycle)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit busy_rand = 1'b0;
    bit busy_force = 1'b0;
    logic [8:0] exp0 [$];
    logic [8:0] exp1 [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send(input int ch, input logic v, input logic [7:0] d, input bit track);
        @(negedge clk);
        while (!in_ready[ch]) @(negedge clk);
        in_push[ch] = 1'b1;
        in_flag[ch] = v;
        in_data[ch*8 +: 8] = d;
        if (track) begin
            if (ch == 0) exp0.push_back({v, d + 8'd1});
            else         exp1.push_back({v, d});
        end
        @(negedge clk);
        in_push[ch] = 1'b0;
    endtask

    task automatic take(input int ch, input bit jitter);
        logic [8:0] got, want;
        if (jitter) repeat ($urandom_range(0, 3)) @(negedge clk);
        @(negedge clk);
        while (!out_valid[ch]) @(negedge clk);
        got  = {out_flag[ch], out_data[ch*8 +: 8]};
        want = (ch == 0) ? exp0.pop_front() : exp1.pop_front();
        chk(got == want, (want[8] == 1'b0 && ch == 0) ? "R1/R5 token" : "R5 token",
            32'(got), 32'(want));
        out_pop[ch] = 1'b1;
        @(negedge clk);
        out_pop[ch] = 1'b0;
    endtask

    always @(negedge clk)
        unit_busy <= busy_rand ? ($urandom_range(0, 3) == 0) : busy_force;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp0.push_back(9'h001);
        exp0.push_back(9'h001);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // reset state: R10, R7, R2 (channel 1 empty so no advance)
        chk(out_valid == 2'b00, "R10 out_valid", 32'(out_valid), 32'h0);
        chk(in_ready == 2'b11, "R10 in_ready", 32'(in_ready), 32'h3);
        chk(tgt_cycle == 0, "R7 reset count", tgt_cycle, 32'h0);
        chk(tgt_cycle == 0 && !tgt_adv, "R2 no advance with empty input", tgt_cycle, 32'h0);

        // table-driven main run with random gaps and busy: R1, R4, R5
        busy_rand = 1'b1;
        fork
            for (int k = 0; k < NV; k++) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                send(0, VEC[k][8], VEC[k][7:0], 1'b1);
            end
            for (int k = 0; k < NV; k++) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                send(1, VEC[k][8], VEC[k][7:0] ^ 8'h5A, 1'b1);
            end
            for (int k = 0; k < NV; k++) take(0, 1'b1);
            for (int k = 0; k < NV; k++) take(1, 1'b1);
        join
        busy_rand = 1'b0;
        repeat (3) @(negedge clk);
        chk(tgt_cycle == 32'd12, "R7 count after run", tgt_cycle, 32'd12);

        // single step: R8
        dbg_stall = 1'b1;
        send(1, 1'b1, 8'hA1, 1'b1);
        send(1, 1'b1, 8'hA2, 1'b1);
        repeat (4) @(negedge clk);
        chk(tgt_cycle == 32'd12, "R8 frozen", tgt_cycle, 32'd12);
        dbg_step = 1'b1;
        @(negedge clk);
        dbg_step = 1'b0;
        repeat (3) @(negedge clk);
        chk(tgt_cycle == 32'd13, "R8 first step", tgt_cycle, 32'd13);
        dbg_step = 1'b1;
        @(negedge clk);
        dbg_step = 1'b0;
        repeat (4) @(negedge clk);
        chk(tgt_cycle == 32'd14, "R8 second step", tgt_cycle, 32'd14);
        take(0, 1'b0); take(0, 1'b0);
        take(1, 1'b0); take(1, 1'b0);
        dbg_stall = 1'b0;

        // backpressure: R3, R6
        for (int k = 0; k < 4; k++) send(0, 1'b1, 8'h40 + 8'(k), 1'b1);
        for (int k = 0; k < 4; k++) send(1, 1'b1, 8'h60 + 8'(k), 1'b1);
        repeat (4) @(negedge clk);
        chk(tgt_cycle == 32'd18, "R3 fill outputs", tgt_cycle, 32'd18);
        for (int k = 0; k < 4; k++) send(0, 1'b1, 8'h50 + 8'(k), 1'b1);
        for (int k = 0; k < 4; k++) send(1, 1'b1, 8'h70 + 8'(k), 1'b1);
        repeat (5) @(negedge clk);
        chk(tgt_cycle == 32'd18, "R3 held by full outputs", tgt_cycle, 32'd18);
        chk(in_ready == 2'b00, "R6 ready low when full", 32'(in_ready), 32'h0);
        in_push[0] = 1'b1; in_flag[0] = 1'b1; in_data[7:0] = 8'hEE;
        @(negedge clk);
        in_push[0] = 1'b0;
        fork
            for (int k = 0; k < 8; k++) take(0, 1'b1);
            for (int k = 0; k < 8; k++) take(1, 1'b1);
        join
        repeat (3) @(negedge clk);
        chk(tgt_cycle == 32'd22, "R7 count after drain", tgt_cycle, 32'd22);
        chk(out_valid == 2'b00, "R6 full push discarded", 32'(out_valid), 32'h0);
        out_pop[1] = 1'b1;
        @(negedge clk);
        out_pop[1] = 1'b0;

        // free-running mode with busy held: R4, R9
        busy_force = 1'b1;
        repeat (2) @(negedge clk);
        fast_mode = 1'b1;
        send(1, 1'b0, 8'h00, 1'b0);
        send(1, 1'b1, 8'h77, 1'b1);
        send(0, 1'b1, 8'h30, 1'b1);
        repeat (5) @(negedge clk);
        chk(out_valid == 2'b00, "R4 busy blocks advance", 32'(out_valid), 32'h0);
        busy_force = 1'b0;
        repeat (4) @(negedge clk);
        chk(out_valid == 2'b11, "R9 advance in free mode", 32'(out_valid), 32'h3);
        chk(tgt_cycle == 32'd22, "R9 counter held", tgt_cycle, 32'd22);
        take(0, 1'b0);
        take(1, 1'b0);
        fast_mode = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule